// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block gives a processor word-wide control of four groups of general-purpose pins through a small memory-mapped register bus: a byte address, a write enable, 32-bit write data and combinational 32-bit read data. Three groups are plain bidirectional ports of 8, 24 and 13 pins. The fourth group mixes 6 bidirectional pins, 23 input-only pins and 24 output-only pins, and packs them into shared 32-bit words at fixed, non-contiguous bit positions that software and the pad ring both depend on.

Output levels, pin directions and the port-2 routing-select bits never take a plain write. Each is changed only by writing ones to a "raise" address or to a "lower" address, so one pin can be changed without a read-modify-write and without disturbing the others. Separate state addresses return the stored values. Every pad input passes through a two-flop synchroniser before it can be read. The output enable of each pad comes directly from its direction bit and the driven level from its stored output bit. Software loads the level first and then turns on the direction, so a pad begins to drive with the level already in place.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: A synchronous reset clears every output, direction and routing-select bit: all pads are inputs (enable 0) with their output level 0.
- R2: A write to a raise address sets to 1 each state bit whose write-data bit is 1 and leaves bits written 0 unchanged; the new value appears on the pads and in reads in the cycle after the write edge.
- R3: A write to a lower address clears to 0 each state bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R4: A direction bit of 1 makes the pad an output (enable 1, driving its stored level); a direction bit of 0 makes it an input (enable 0).
- R5: Port 0 (8 pins) and port 1 (24 pins) use bits from 0 upward. Port 0 byte offsets: input 0x40, output raise 0x44, output lower 0x48, output state 0x4C, direction raise 0x50, direction lower 0x54, direction state 0x58. Port 1 uses the same order at 0x60 to 0x78.
- R6: Port 2 (13 pins, bits 0 to 12): direction raise 0x10, lower 0x14, state 0x18; input 0x1C; output raise 0x20, lower 0x24 (no output state address); routing-select raise 0x28, lower 0x2C, state 0x30. Routing-select bits do not affect the pads.
- R7: The fourth-port output word has raise 0x04, lower 0x08 and state 0x0C. Bits 0 to 23 drive the 24 output-only pins and bits 25 to 30 drive bidirectional pins 0 to 5; bits 24 and 31 do not exist, ignore writes and read 0.
- R8: The direction of fourth-port bidirectional pin n (n = 0 to 5) is bit n+25 of the port-2 direction raise, lower and state addresses.
- R9: The fourth-port input word at 0x00 reads bidirectional pins 0 to 4 at bits 10 to 14 and pin 5 at bit 24. Input-only pins 0 to 9 read at bits 0 to 9, pins 10 to 18 at bits 15 to 23 and pins 19 to 22 at bits 25 to 28. Bits 29 to 31 read 0.
- R10: A pad input value that is held steady appears in its input word after the second rising clock edge that samples it, not after the first.
- R11: Reads of raise and lower addresses, of unmapped or unaligned offsets and of offsets at or above 0x100 return 0; writes to input, state, unmapped or unaligned offsets change nothing.
- R12: When a direction bit goes from 0 to 1, the pad's output level in that cycle equals its level in the cycle before, so the pad drives the previously stored level from its first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| p0_in | input | 8 | Port 0 pad inputs |
| p0_out | output | 8 | Port 0 pad output levels |
| p0_oe | output | 8 | Port 0 pad output enables |
| p1_in | input | 24 | Port 1 pad inputs |
| p1_out | output | 24 | Port 1 pad output levels |
| p1_oe | output | 24 | Port 1 pad output enables |
| p2_in | input | 13 | Port 2 pad inputs |
| p2_out | output | 13 | Port 2 pad output levels |
| p2_oe | output | 13 | Port 2 pad output enables |
| p3_io_in | input | 6 | Fourth-port bidirectional pad inputs |
| p3_io_out | output | 6 | Fourth-port bidirectional pad output levels |
| p3_io_oe | output | 6 | Fourth-port bidirectional pad output enables |
| p3_gpi_in | input | 23 | Fourth-port input-only pins |
| p3_gpo_out | output | 24 | Fourth-port output-only pin levels |

## Verification
The assertions take for granted that the bus performs at most one write per cycle, so a raise and a lower of the same bit never meet in one cycle, and that reset is held from time zero across at least one clock edge. They also assume the pad inputs are sampled only at clock edges, which the synchroniser check relies on. The stimulus issues each access as a single strobed cycle, and it changes pad inputs and bus signals only between edges. Random accesses are spread over every aligned offset below 0x80, with occasional unaligned ones, so unmapped and read-only offsets are hit without ever producing two writes in one cycle.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    localparam int DW         = 32;
    localparam int P0_W       = 8;
    localparam int P1_W       = 24;
    localparam int P2_W       = 13;
    localparam int P3_IO_N    = 6;
    localparam int P3_GPI_N   = 23;
    localparam int P3_GPO_N   = 24;
    localparam int P3_IO_LSB  = 25;   // bidir outputs and directions start here
    localparam int P3_IO_MSB  = P3_IO_LSB + P3_IO_N - 1;

    typedef enum logic [4:0] {
        RS_NONE,
        RS_P3_IN,  RS_P3_ORAISE, RS_P3_OLOWER, RS_P3_OSTATE,
        RS_P2_DRAISE, RS_P2_DLOWER, RS_P2_DSTATE, RS_P2_IN,
        RS_P2_ORAISE, RS_P2_OLOWER,
        RS_P2_MRAISE, RS_P2_MLOWER, RS_P2_MSTATE,
        RS_P0_IN, RS_P0_ORAISE, RS_P0_OLOWER, RS_P0_OSTATE,
        RS_P0_DRAISE, RS_P0_DLOWER, RS_P0_DSTATE,
        RS_P1_IN, RS_P1_ORAISE, RS_P1_OLOWER, RS_P1_OSTATE,
        RS_P1_DRAISE, RS_P1_DLOWER, RS_P1_DSTATE
    } reg_sel_e;

    typedef struct packed {
        logic raise;
        logic lower;
    } sc_strobe_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] a);
        case (a)
            8'h00: return RS_P3_IN;
            8'h04: return RS_P3_ORAISE;
            8'h08: return RS_P3_OLOWER;
            8'h0C: return RS_P3_OSTATE;
            8'h10: return RS_P2_DRAISE;
            8'h14: return RS_P2_DLOWER;
            8'h18: return RS_P2_DSTATE;
            8'h1C: return RS_P2_IN;
            8'h20: return RS_P2_ORAISE;
            8'h24: return RS_P2_OLOWER;
            8'h28: return RS_P2_MRAISE;
            8'h2C: return RS_P2_MLOWER;
            8'h30: return RS_P2_MSTATE;
            8'h40: return RS_P0_IN;
            8'h44: return RS_P0_ORAISE;
            8'h48: return RS_P0_OLOWER;
            8'h4C: return RS_P0_OSTATE;
            8'h50: return RS_P0_DRAISE;
            8'h54: return RS_P0_DLOWER;
            8'h58: return RS_P0_DSTATE;
            8'h60: return RS_P1_IN;
            8'h64: return RS_P1_ORAISE;
            8'h68: return RS_P1_OLOWER;
            8'h6C: return RS_P1_OSTATE;
            8'h70: return RS_P1_DRAISE;
            8'h74: return RS_P1_DLOWER;
            8'h78: return RS_P1_DSTATE;
            default: return RS_NONE;
        endcase
    endfunction

    function automatic sc_strobe_t strobes(input logic we, input reg_sel_e sel,
                                           input reg_sel_e up, input reg_sel_e dn);
        sc_strobe_t s;
        s.raise = we && (sel == up);
        s.lower = we && (sel == dn);
        return s;
    endfunction

    // Fourth-port input word: irregular packing shared by pads and software.
    function automatic logic [DW-1:0] pack_p3_inputs(input logic [P3_GPI_N-1:0] gpi,
                                                     input logic [P3_IO_N-1:0]  io);
        return {3'b000, gpi[22:19], io[5], gpi[18:10], io[4:0], gpi[9:0]};
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg
    import gpio_setclr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sc_strobe_t   stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    logic [W-1:0] up_mask;
    logic [W-1:0] dn_mask;

    always_comb begin
        up_mask = stb.raise ? bits : '0;
        dn_mask = stb.lower ? bits : '0;
    end

    // Lower wins if both ever arrive together.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | up_mask) & ~dn_mask;
    end
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [P0_W-1:0]     p0_in,
    output logic [P0_W-1:0]     p0_out,
    output logic [P0_W-1:0]     p0_oe,
    input  logic [P1_W-1:0]     p1_in,
    output logic [P1_W-1:0]     p1_out,
    output logic [P1_W-1:0]     p1_oe,
    input  logic [P2_W-1:0]     p2_in,
    output logic [P2_W-1:0]     p2_out,
    output logic [P2_W-1:0]     p2_oe,
    input  logic [P3_IO_N-1:0]  p3_io_in,
    output logic [P3_IO_N-1:0]  p3_io_out,
    output logic [P3_IO_N-1:0]  p3_io_oe,
    input  logic [P3_GPI_N-1:0] p3_gpi_in,
    output logic [P3_GPO_N-1:0] p3_gpo_out
);
    localparam int P0_PAD = DW - P0_W;
    localparam int P1_PAD = DW - P1_W;
    localparam int P2_PAD = DW - P2_W;
    localparam int DIR_GAP = P3_IO_LSB - P2_W;
    localparam int GPO_GAP = P3_IO_LSB - P3_GPO_N;

    reg_sel_e sel;
    logic     addr_in_window;

    always_comb begin
        addr_in_window = (bus_addr >> 8) == '0;
        sel = addr_in_window ? decode_offset(bus_addr[7:0]) : RS_NONE;
    end

    // Write data bits that no field occupies.
    logic wbits_unused;
    assign wbits_unused = ^{bus_wdata[DW-1], bus_wdata[P3_GPO_N]};

    // ---------------- state registers ----------------
    logic [P2_W-1:0]     mux2_q;
    logic [P3_IO_N-1:0]  dir3_q;

    gpio_setclr_reg #(.W(P0_W)) u_out0 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P0_ORAISE, RS_P0_OLOWER)),
        .bits(bus_wdata[P0_W-1:0]), .q(p0_out));
    gpio_setclr_reg #(.W(P0_W)) u_dir0 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P0_DRAISE, RS_P0_DLOWER)),
        .bits(bus_wdata[P0_W-1:0]), .q(p0_oe));
    gpio_setclr_reg #(.W(P1_W)) u_out1 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P1_ORAISE, RS_P1_OLOWER)),
        .bits(bus_wdata[P1_W-1:0]), .q(p1_out));
    gpio_setclr_reg #(.W(P1_W)) u_dir1 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P1_DRAISE, RS_P1_DLOWER)),
        .bits(bus_wdata[P1_W-1:0]), .q(p1_oe));
    gpio_setclr_reg #(.W(P2_W)) u_out2 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P2_ORAISE, RS_P2_OLOWER)),
        .bits(bus_wdata[P2_W-1:0]), .q(p2_out));
    gpio_setclr_reg #(.W(P2_W)) u_dir2 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P2_DRAISE, RS_P2_DLOWER)),
        .bits(bus_wdata[P2_W-1:0]), .q(p2_oe));
    gpio_setclr_reg #(.W(P2_W)) u_mux2 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P2_MRAISE, RS_P2_MLOWER)),
        .bits(bus_wdata[P2_W-1:0]), .q(mux2_q));
    // Fourth-port bidir directions live in the upper bits of the port-2 direction word.
    gpio_setclr_reg #(.W(P3_IO_N)) u_dir3 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P2_DRAISE, RS_P2_DLOWER)),
        .bits(bus_wdata[P3_IO_MSB:P3_IO_LSB]), .q(dir3_q));
    gpio_setclr_reg #(.W(P3_GPO_N)) u_gpo3 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P3_ORAISE, RS_P3_OLOWER)),
        .bits(bus_wdata[P3_GPO_N-1:0]), .q(p3_gpo_out));
    gpio_setclr_reg #(.W(P3_IO_N)) u_io3 (.clk, .rst,
        .stb(strobes(bus_we, sel, RS_P3_ORAISE, RS_P3_OLOWER)),
        .bits(bus_wdata[P3_IO_MSB:P3_IO_LSB]), .q(p3_io_out));

    assign p3_io_oe = dir3_q;

    // ---------------- input synchronisers ----------------
    logic [P0_W-1:0] in0_s;
    logic [P1_W-1:0] in1_s;
    logic [P2_W-1:0] in2_s;
    logic [DW-1:0]   in3_s;

    gpio_sync2 #(.W(P0_W)) u_sy0 (.clk, .rst, .d(p0_in), .q(in0_s));
    gpio_sync2 #(.W(P1_W)) u_sy1 (.clk, .rst, .d(p1_in), .q(in1_s));
    gpio_sync2 #(.W(P2_W)) u_sy2 (.clk, .rst, .d(p2_in), .q(in2_s));
    gpio_sync2 #(.W(DW))   u_sy3 (.clk, .rst,
        .d(pack_p3_inputs(p3_gpi_in, p3_io_in)), .q(in3_s));

    // ---------------- read path ----------------
    always_comb begin
        case (sel)
            RS_P3_IN:     bus_rdata = in3_s;
            RS_P3_OSTATE: bus_rdata = {1'b0, p3_io_out, {GPO_GAP{1'b0}}, p3_gpo_out};
            RS_P2_DSTATE: bus_rdata = {1'b0, dir3_q, {DIR_GAP{1'b0}}, p2_oe};
            RS_P2_IN:     bus_rdata = {{P2_PAD{1'b0}}, in2_s};
            RS_P2_MSTATE: bus_rdata = {{P2_PAD{1'b0}}, mux2_q};
            RS_P0_IN:     bus_rdata = {{P0_PAD{1'b0}}, in0_s};
            RS_P0_OSTATE: bus_rdata = {{P0_PAD{1'b0}}, p0_out};
            RS_P0_DSTATE: bus_rdata = {{P0_PAD{1'b0}}, p0_oe};
            RS_P1_IN:     bus_rdata = {{P1_PAD{1'b0}}, in1_s};
            RS_P1_OSTATE: bus_rdata = {{P1_PAD{1'b0}}, p1_out};
            RS_P1_DSTATE: bus_rdata = {{P1_PAD{1'b0}}, p1_oe};
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_setclr_ctrl_chk.sv
module gpio_setclr_ctrl_chk
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DW-1:0]       bus_wdata,
    input logic [DW-1:0]       bus_rdata,
    input logic [P0_W-1:0]     p0_in,
    input logic [P0_W-1:0]     p0_out,
    input logic [P0_W-1:0]     p0_oe,
    input logic [P1_W-1:0]     p1_in,
    input logic [P1_W-1:0]     p1_out,
    input logic [P1_W-1:0]     p1_oe,
    input logic [P2_W-1:0]     p2_in,
    input logic [P2_W-1:0]     p2_out,
    input logic [P2_W-1:0]     p2_oe,
    input logic [P3_IO_N-1:0]  p3_io_in,
    input logic [P3_IO_N-1:0]  p3_io_out,
    input logic [P3_IO_N-1:0]  p3_io_oe,
    input logic [P3_GPI_N-1:0] p3_gpi_in,
    input logic [P3_GPO_N-1:0] p3_gpo_out
);
    logic inputs_unused;
    assign inputs_unused = ^{p1_in, p2_in, p3_io_in, p3_gpi_in};

    function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (p0_oe == '0 && p1_oe == '0 && p2_oe == '0 && p3_io_oe == '0
                        && p0_out == '0 && p1_out == '0 && p2_out == '0
                        && p3_io_out == '0 && p3_gpo_out == '0));

    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && at(bus_addr, 8'h44)) |=>
        ((p0_out & $past(bus_wdata[P0_W-1:0])) == $past(bus_wdata[P0_W-1:0])));

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && (at(bus_addr, 8'h44) || at(bus_addr, 8'h48))) |=> $stable(p0_out));

    assert_lower_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && at(bus_addr, 8'h68)) |=>
        ((p1_out & $past(bus_wdata[P1_W-1:0])) == '0));

    assert_gpo_readback_R7: assert property (@(posedge clk) disable iff (rst)
        at(bus_addr, 8'h0C) |-> (bus_rdata[P3_GPO_N-1:0] == p3_gpo_out
                                 && bus_rdata[P3_IO_MSB:P3_IO_LSB] == p3_io_out
                                 && !bus_rdata[DW-1] && !bus_rdata[P3_GPO_N]));

    assert_bidir_dir_word_R8: assert property (@(posedge clk) disable iff (rst)
        at(bus_addr, 8'h18) |-> (bus_rdata[P3_IO_MSB:P3_IO_LSB] == p3_io_oe
                                 && bus_rdata[P2_W-1:0] == p2_oe));

    assert_sync_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && at(bus_addr, 8'h40)) |-> (bus_rdata[P0_W-1:0] == $past(p0_in, 2)));

    assert_strobe_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (at(bus_addr, 8'h04) || at(bus_addr, 8'h14) || at(bus_addr, 8'h24)
         || at(bus_addr, 8'h2C) || at(bus_addr, 8'h48) || at(bus_addr, 8'h70)
         || at(bus_addr, 8'h3C)) |-> (bus_rdata == '0));

    assert_enable_keeps_level_R12: assert property (@(posedge clk) disable iff (rst)
        ((p1_oe & ~$past(p1_oe)) != '0) |->
        (((p1_out ^ $past(p1_out)) & p1_oe & ~$past(p1_oe)) == '0));

    assert_enable_keeps_level_p3_R12: assert property (@(posedge clk) disable iff (rst)
        ((p3_io_oe & ~$past(p3_io_oe)) != '0) |->
        (((p3_io_out ^ $past(p3_io_out)) & p3_io_oe & ~$past(p3_io_oe)) == '0));
endmodule

bind gpio_setclr_ctrl gpio_setclr_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_setclr_ctrl_tb_top.sv
module gpio_setclr_ctrl_tb_top;
    localparam int PER = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  p0_in = '0, p0_out, p0_oe;
    logic [23:0] p1_in = '0, p1_out, p1_oe;
    logic [12:0] p2_in = '0, p2_out, p2_oe;
    logic [5:0]  p3_io_in = '0, p3_io_out, p3_io_oe;
    logic [22:0] p3_gpi_in = '0;
    logic [23:0] p3_gpo_out;

    always #(PER/2) clk = ~clk;

    gpio_setclr_ctrl dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam logic [31:0] OUT3_MASK = 32'h7EFF_FFFF;
    logic [7:0]  m_o0, m_d0;
    logic [23:0] m_o1, m_d1;
    logic [12:0] m_o2, m_d2, m_mx;
    logic [5:0]  m_d3;
    logic [31:0] m_o3;
    logic [73:0] seen_q[$];   // pad samples, newest at back
    logic        armed = 1'b0;

    always @(posedge clk) begin
        armed <= 1'b1;
        seen_q.push_back({p3_gpi_in, p3_io_in, p2_in, p1_in, p0_in});
        if (seen_q.size() > 2) void'(seen_q.pop_front());
        if (rst) begin
            m_o0 <= '0; m_d0 <= '0; m_o1 <= '0; m_d1 <= '0;
            m_o2 <= '0; m_d2 <= '0; m_mx <= '0; m_d3 <= '0; m_o3 <= '0;
            seen_q.delete();
        end else if (bus_we) begin
            case (bus_addr)
                8'h04: m_o3 <= (m_o3 | bus_wdata) & OUT3_MASK;
                8'h08: m_o3 <= m_o3 & ~bus_wdata;
                8'h10: begin m_d2 <= m_d2 | bus_wdata[12:0]; m_d3 <= m_d3 | bus_wdata[30:25]; end
                8'h14: begin m_d2 <= m_d2 & ~bus_wdata[12:0]; m_d3 <= m_d3 & ~bus_wdata[30:25]; end
                8'h20: m_o2 <= m_o2 | bus_wdata[12:0];
                8'h24: m_o2 <= m_o2 & ~bus_wdata[12:0];
                8'h28: m_mx <= m_mx | bus_wdata[12:0];
                8'h2C: m_mx <= m_mx & ~bus_wdata[12:0];
                8'h44: m_o0 <= m_o0 | bus_wdata[7:0];
                8'h48: m_o0 <= m_o0 & ~bus_wdata[7:0];
                8'h50: m_d0 <= m_d0 | bus_wdata[7:0];
                8'h54: m_d0 <= m_d0 & ~bus_wdata[7:0];
                8'h64: m_o1 <= m_o1 | bus_wdata[23:0];
                8'h68: m_o1 <= m_o1 & ~bus_wdata[23:0];
                8'h70: m_d1 <= m_d1 | bus_wdata[23:0];
                8'h74: m_d1 <= m_d1 & ~bus_wdata[23:0];
                default: ;
            endcase
        end
    end

    // Synchronised view: the sample taken two edges back (zeros right after reset).
    function automatic logic [73:0] synced();
        if (seen_q.size() < 2) return '0;
        return seen_q[0];
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [73:0] s = synced();
        logic [31:0] r = '0;
        case (a)
            8'h00: begin
                for (int i = 0; i < 23; i++) begin
                    int pos = (i < 10) ? i : ((i < 19) ? i + 5 : i + 6);
                    r[pos] = s[51 + i];
                end
                for (int j = 0; j < 6; j++) r[(j < 5) ? 10 + j : 24] = s[45 + j];
            end
            8'h0C: r = m_o3;
            8'h18: r = 32'(m_d2) | (32'(m_d3) << 25);
            8'h1C: r = 32'(s[44:32]);
            8'h30: r = 32'(m_mx);
            8'h40: r = 32'(s[7:0]);
            8'h4C: r = 32'(m_o0);
            8'h58: r = 32'(m_d0);
            8'h60: r = 32'(s[31:8]);
            8'h6C: r = 32'(m_o1);
            8'h78: r = 32'(m_d1);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        if (a[1:0] != 2'b00)                 return "R11 unaligned read";
        if (a == 8'h00)                      return "R9 fourth-port input read";
        if (a == 8'h0C)                      return "R7 fourth-port output read";
        if (a == 8'h18)                      return "R8 port2 direction read";
        if (a == 8'h1C || a == 8'h40 || a == 8'h60) return "R10 input read";
        if (a == 8'h30)                      return "R6 routing-select read";
        if (a >= 8'h40 && a < 8'h60)         return "R5 port0 read";
        if (a >= 8'h60)                      return "R5 port1 read";
        return "R11 strobe or unmapped read";
    endfunction

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            chk("R2 p0_out", 32'(p0_out), 32'(m_o0));
            chk("R4 p0_oe",  32'(p0_oe),  32'(m_d0));
            chk("R3 p1_out", 32'(p1_out), 32'(m_o1));
            chk("R4 p1_oe",  32'(p1_oe),  32'(m_d1));
            chk("R6 p2_out", 32'(p2_out), 32'(m_o2));
            chk("R6 p2_oe",  32'(p2_oe),  32'(m_d2));
            chk("R7 p3_gpo_out", 32'(p3_gpo_out), m_o3 & 32'h00FF_FFFF);
            chk("R7 p3_io_out",  32'(p3_io_out),  32'(m_o3[30:25]));
            chk("R8 p3_io_oe",   32'(p3_io_oe),   32'(m_d3));
            chk(read_tag(bus_addr), bus_rdata, exp_read(bus_addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #5;
        bus_we = 1'b0;
    endtask

    task automatic settle_read(input logic [7:0] a);
        bus_addr = a;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #5;
        settle_read(8'h4C);
        chk("R1 reset p1_oe", 32'(p1_oe), 32'h0);
        chk("R1 reset p3_io_oe", 32'(p3_io_oe), 32'h0);
        @(posedge clk); #5;
        rst = 1'b0;

        // R2/R3: raise then lower with partial masks.
        bus_wr(8'h44, 32'h0000_00A5);
        bus_wr(8'h44, 32'h0000_0010);
        bus_wr(8'h48, 32'h0000_0081);
        settle_read(8'h4C);
        chk("R2 R3 p0 output state", bus_rdata, 32'h0000_0034);

        // R12: level first, then direction.
        bus_wr(8'h64, 32'h0000_0008);
        @(negedge clk);
        chk("R12 level before enable", {31'b0, p1_out[3]}, 32'h1);
        chk("R12 still input", {31'b0, p1_oe[3]}, 32'h0);
        #1;
        bus_wr(8'h70, 32'h0000_0008);
        @(negedge clk);
        chk("R12 R4 enabled drives stored level", {30'b0, p1_oe[3], p1_out[3]}, 32'h3);
        #1;

        // R7: nonexistent bits 24 and 31.
        bus_wr(8'h04, 32'hFFFF_FFFF);
        settle_read(8'h0C);
        chk("R7 fourth-port output state", bus_rdata, 32'h7EFF_FFFF);
        bus_wr(8'h08, 32'h5500_FF00);
        settle_read(8'h0C);
        chk("R7 partial lower", bus_rdata, 32'h2AFF_00FF);

        // R8: bidir directions via port-2 direction word.
        bus_wr(8'h10, 32'h4200_1001);
        settle_read(8'h18);
        chk("R8 direction word", bus_rdata, 32'h4200_1001);
        chk("R8 bidir enables", 32'(p3_io_oe), 32'h21);

        // R6: routing-select bits leave pads alone.
        bus_wr(8'h28, 32'h0000_1FFF);
        settle_read(8'h30);
        chk("R6 routing state", bus_rdata, 32'h0000_1FFF);
        chk("R6 pads unaffected by routing", 32'(p2_oe), 32'h1001);

        // R9 and R10: packing and two-edge latency.
        bus_addr = 8'h00;
        p3_gpi_in = 23'h7F_FFFF; p3_io_in = 6'h00;
        @(negedge clk);
        chk("R10 not visible after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R9 input-only packing", bus_rdata, 32'h1EFF_83FF);
        #1;
        p3_gpi_in = '0; p3_io_in = 6'h3F;
        repeat (2) @(negedge clk);
        chk("R9 bidir input packing", bus_rdata, 32'h0100_7C00);
        #1;

        // R11: writes to read-only, unmapped and unaligned offsets.
        bus_wr(8'h4C, 32'hFFFF_FFFF);
        bus_wr(8'h3C, 32'hFFFF_FFFF);
        bus_wr(8'h45, 32'hFFFF_FFFF);
        settle_read(8'h4C);
        chk("R11 ignored writes leave p0 state", bus_rdata, 32'h0000_0034);
        settle_read(8'h3C);
        chk("R11 unmapped read", bus_rdata, 32'h0);

        // Random traffic compared against the model every cycle.
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 31) << 2);
            if ($urandom_range(0, 15) == 0) a = a | 8'h1;
            bus_addr  = a;
            bus_we    = ($urandom_range(0, 2) != 0);
            bus_wdata = $urandom;
            p0_in = 8'($urandom); p1_in = 24'($urandom); p2_in = 13'($urandom);
            p3_io_in = 6'($urandom); p3_gpi_in = 23'($urandom);
            if ($urandom_range(0, 200) == 0) rst = 1'b1; else rst = 1'b0;
            @(posedge clk); #5;
        end
        bus_we = 1'b0; rst = 1'b0;
        repeat (3) @(posedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule